// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This block gives a small CPU one hardware address breakpoint for its debug logic. It holds a match address and an 8-bit control/status register. Both are loaded by debug commands. The unit watches the CPU's address bus and, when the match address is seen, asks the core to stop and enter background mode. Two request styles are offered. In forced mode, any access to the match address arms a request, and the request fires at the next instruction boundary. In tagged mode, only an opcode fetch from the match address is marked. The request fires only if that marked instruction reaches the head of the instruction queue and leaves it, so the core can enter background mode instead of running it.

The CPU pipeline is not part of this block. It appears only as a few strobes: a bus access, an opcode fetch into the queue, an instruction boundary, a pop at the queue head, and a queue flush. Debug commands arrive on a valid/ready port. `cmd_ready` is held high, so a command is taken in every cycle where `cmd_valid` is high, and there is never back-pressure. Core state bits (background active, wait status, wait flag, data-valid flag) are sampled into the upper half of the control register, where they can only be read.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, `ctrl_q` is 0x00 (with all status inputs low), `match_q` is 0 and `brk_req` is low.
- R2: A command with `cmd_op` = 2'b10 loads `cmd_data` into the match register, and `match_q` shows it in the following cycle.
- R3: With control bit 0 (enable) = 1 and bit 1 (forced select) = 1, a `cpu_acc` at the match address followed by a later `cpu_bound` drives `brk_req` high, with `brk_tagged` low, in the cycle after that boundary. Accesses at other addresses raise nothing.
- R4: In forced mode, a boundary that occurs in the same cycle as the matching access does not fire the request. The request waits for the next boundary, and one armed request fires only once.
- R5: With bit 1 = 0 (tagged mode), a `cpu_fetch` at the match address marks that queue entry. When that entry leaves the head on `q_pop`, `brk_req` and `brk_tagged` are high in the next cycle. Unmarked entries, and plain data accesses in this mode, raise nothing.
- R6: `q_flush` discards every mark in the queue, so a later pop raises no request.
- R7: While bit 0 (enable) is 0, no request is raised. Hits seen while the unit is disabled are not remembered after it is enabled.
- R8: Bit 3 (debug enable) takes the value written by a control write (`cmd_op` = 2'b01) only while `st_bg_active` is low. While `st_bg_active` is high, the bit keeps its value.
- R9: Bits 7..4 of `ctrl_q` show, one cycle late, data-valid flag, wait flag, wait status and background active (bit 7 down to bit 4). Control writes never change these bits.
- R10: Bit 2 (clock select) is written by every control write, including while in background mode.
- R11: `brk_req` is a one-cycle pulse and is never high in two cycles in a row. A second event in the cycle right after a request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Debug command valid |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_op | input | 2 | 00 none, 01 write control, 10 write match |
| cmd_data | input | ADDR_W | Command payload (control uses bits 7..0) |
| st_bg_active | input | 1 | Core is in background mode |
| st_wait | input | 1 | Core wait status |
| st_wait_flag | input | 1 | Core wait flag |
| st_data_valid | input | 1 | Debug data-valid flag |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_acc | input | 1 | Bus access this cycle |
| cpu_fetch | input | 1 | Opcode fetch into queue this cycle |
| cpu_bound | input | 1 | Instruction boundary this cycle |
| q_pop | input | 1 | Queue head instruction leaves for execution |
| q_flush | input | 1 | Instruction queue flushed |
| brk_req | output | 1 | Background entry request pulse |
| brk_tagged | output | 1 | Request came from a tagged opcode |
| ctrl_q | output | 8 | Control/status register readback |
| match_q | output | ADDR_W | Match register readback |

## Verification
The bench builds the unit with ADDR_W = 16 and QDEPTH = 3. A three-entry queue means a few fetches are enough to mix marked and unmarked entries, drain the queue through its head, pop from an empty queue, and flush with marks pending. Forced and tagged scenarios alternate with control writes, so the enable gating, the debug-enable lock in background mode and the read-only status bits are all exercised in one short run.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  typedef enum logic [1:0] {
    OP_NOP      = 2'b00,
    OP_WR_CTRL  = 2'b01,
    OP_WR_MATCH = 2'b10,
    OP_RSVD     = 2'b11
  } cmd_op_e;

  localparam int CB_EN  = 0;
  localparam int CB_FRC = 1;
  localparam int CB_CLK = 2;
  localparam int CB_DBG = 3;

  typedef struct packed {
    logic dv_flg;
    logic wait_flg;
    logic wait_st;
    logic bg_act;
    logic dbg_en;
    logic clk_sel;
    logic frc_sel;
    logic brk_en;
  } ctrl_t;
endpackage

// File: rtl/dbg_bkpt_regs.sv
module dbg_bkpt_regs
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_data,
  input  logic              st_bg_active,
  input  logic              st_wait,
  input  logic              st_wait_flag,
  input  logic              st_data_valid,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] match
);
  logic wr_ctrl, wr_match;
  assign wr_ctrl  = cmd_valid && (cmd_op == OP_WR_CTRL);
  assign wr_match = cmd_valid && (cmd_op == OP_WR_MATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      match <= '0;
    end else begin
      // status half follows the core, never the command
      ctrl.bg_act   <= st_bg_active;
      ctrl.wait_st  <= st_wait;
      ctrl.wait_flg <= st_wait_flag;
      ctrl.dv_flg   <= st_data_valid;
      if (wr_ctrl) begin
        ctrl.brk_en  <= cmd_data[CB_EN];
        ctrl.frc_sel <= cmd_data[CB_FRC];
        ctrl.clk_sel <= cmd_data[CB_CLK];
        if (!st_bg_active) ctrl.dbg_en <= cmd_data[CB_DBG];
      end
      if (wr_match) match <= cmd_data;
    end
  end

  assert_match_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_match |=> match == $past(cmd_data));
  assert_dbg_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && st_bg_active) |=> $stable(ctrl.dbg_en));
  assert_status_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ({ctrl.dv_flg, ctrl.wait_flg, ctrl.wait_st, ctrl.bg_act} ==
                 $past({st_data_valid, st_wait_flag, st_wait, st_bg_active})));
endmodule

// File: rtl/dbg_bkpt_force.sv
module dbg_bkpt_force #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              frc_sel,
  input  logic [ADDR_W-1:0] match,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_acc,
  input  logic              cpu_bound,
  output logic              addr_hit,
  output logic              frc_evt
);
  logic armed;

  assign addr_hit = (cpu_addr == match);
  assign frc_evt  = armed && cpu_bound;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= (armed && !cpu_bound) || (cpu_acc && addr_hit && en && frc_sel);
  end
endmodule

// File: rtl/dbg_bkpt_tagq.sv
module dbg_bkpt_tagq #(
  parameter int QDEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch,
  input  logic tag_in,
  input  logic pop,
  input  logic flush,
  output logic tag_evt
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic [QDEPTH-1:0] tag_r, tag_nxt, shifted;
  logic [CNT_W-1:0]  cnt;
  logic              pop_eff, full, push_ok;
  logic [CNT_W-1:0]  wr_idx;

  assign pop_eff = pop && (cnt != '0);
  assign full    = (cnt == CNT_W'(QDEPTH));
  assign push_ok = fetch && (!full || pop_eff);
  assign wr_idx  = cnt - CNT_W'(pop_eff);
  assign tag_evt = pop_eff && tag_r[0] && !flush;

  for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
    if (i == QDEPTH - 1) begin : g_top
      assign shifted[i] = 1'b0;
    end else begin : g_mid
      assign shifted[i] = tag_r[i+1];
    end
  end

  always_comb begin
    tag_nxt = pop_eff ? shifted : tag_r;
    for (int i = 0; i < QDEPTH; i++)
      if (push_ok && wr_idx == CNT_W'(i)) tag_nxt[i] = tag_in;
    if (flush) tag_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_r <= '0;
      cnt   <= '0;
    end else begin
      tag_r <= tag_nxt;
      if (flush) cnt <= '0;
      else       cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_eff);
    end
  end

  assert_flush_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch && full && !pop_eff));
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_data,
  input  logic              st_bg_active,
  input  logic              st_wait,
  input  logic              st_wait_flag,
  input  logic              st_data_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_acc,
  input  logic              cpu_fetch,
  input  logic              cpu_bound,
  input  logic              q_pop,
  input  logic              q_flush,
  output logic              brk_req,
  output logic              brk_tagged,
  output logic [7:0]        ctrl_q,
  output logic [ADDR_W-1:0] match_q
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] match;
  logic              addr_hit, frc_evt, tag_evt, raw;

  assign cmd_ready = 1'b1;
  assign ctrl_q    = ctrl;
  assign match_q   = match;

  dbg_bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_data,
    .st_bg_active, .st_wait, .st_wait_flag, .st_data_valid,
    .ctrl, .match
  );

  dbg_bkpt_force #(.ADDR_W(ADDR_W)) u_force (
    .clk, .rst_n, .en(ctrl.brk_en), .frc_sel(ctrl.frc_sel), .match,
    .cpu_addr, .cpu_acc, .cpu_bound, .addr_hit, .frc_evt
  );

  dbg_bkpt_tagq #(.QDEPTH(QDEPTH)) u_tagq (
    .clk, .rst_n, .fetch(cpu_fetch),
    .tag_in(addr_hit && ctrl.brk_en && !ctrl.frc_sel),
    .pop(q_pop), .flush(q_flush), .tag_evt
  );

  assign raw = (frc_evt || tag_evt) && ctrl.brk_en && !brk_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req    <= 1'b0;
      brk_tagged <= 1'b0;
    end else begin
      brk_req    <= raw;
      brk_tagged <= raw && !frc_evt;
    end
  end

  assert_en_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(ctrl.brk_en));
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);
endmodule

// File: tb/dbg_bkpt_unit_test.sv
`timescale 1ns/1ps
module dbg_bkpt_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [15:0] cmd_data = 0;
  logic st_bg_active = 0, st_wait = 0, st_wait_flag = 0, st_data_valid = 0;
  logic [15:0] cpu_addr = 0;
  logic cpu_acc = 0, cpu_fetch = 0, cpu_bound = 0, q_pop = 0, q_flush = 0;
  logic brk_req, brk_tagged;
  logic [7:0] ctrl_q;
  logic [15:0] match_q;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit req; bit tg; string rid; } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  dbg_bkpt_unit #(.ADDR_W(16), .QDEPTH(3)) uut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_data,
    .st_bg_active, .st_wait, .st_wait_flag, .st_data_valid,
    .cpu_addr, .cpu_acc, .cpu_fetch, .cpu_bound, .q_pop, .q_flush,
    .brk_req, .brk_tagged, .ctrl_q, .match_q
  );

  task automatic chk(input string rid, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", rid, act, exp);
    end
  endtask

  // monitor: one expected item per driven cycle
  always @(negedge clk) begin
    exp_t e;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      chk({e.rid, " brk_req"}, int'(brk_req), int'(e.req));
      if (e.req) chk({e.rid, " brk_tagged"}, int'(brk_tagged), int'(e.tg));
    end
  end

  task automatic push(input bit er, input bit et, input string rid);
    exp_t e;
    e.req = er; e.tg = et; e.rid = rid;
    sbq.push_back(e);
  endtask

  task automatic cyc(input logic a, input logic f, input logic b, input logic p,
                     input logic fl, input logic [15:0] ad,
                     input bit er, input bit et, input string rid);
    @(negedge clk);
    cpu_acc = a; cpu_fetch = f; cpu_bound = b; q_pop = p; q_flush = fl; cpu_addr = ad;
    @(posedge clk); #1;
    cpu_acc = 0; cpu_fetch = 0; cpu_bound = 0; q_pop = 0; q_flush = 0;
    push(er, et, rid);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 0;
    push(0, 0, "R11");
  endtask

  task automatic rd_ctrl(input string rid, input int exp);
    @(negedge clk); #1;
    chk({rid, " ctrl_q"}, int'(ctrl_q), exp);
  endtask

  localparam logic [15:0] M = 16'h1234;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ctrl_q", int'(ctrl_q), 0);
    chk("R1 match_q", int'(match_q), 0);
    chk("R1 brk_req", int'(brk_req), 0);
    rst_n = 1;

    cmd(2'b10, M);
    @(negedge clk); #1; chk("R2 match_q", int'(match_q), int'(M));
    cmd(2'b01, 16'h000B);
    rd_ctrl("R8", 8'h0B);

    // forced mode
    cyc(1, 0, 0, 0, 0, M, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, 1, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 1, 0, 0, M, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, 0, 1, 0, "R4");
    cyc(1, 0, 0, 0, 0, M + 16'h1, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R3");

    // disabled
    cmd(2'b01, 16'h000A);
    cyc(1, 0, 0, 0, 0, M, 0, 0, "R7");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R7");
    cmd(2'b01, 16'h000B);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R7");

    // tagged mode
    cmd(2'b01, 16'h0009);
    rd_ctrl("R5", 8'h09);
    cyc(0, 1, 0, 0, 0, M, 0, 0, "R5");
    cyc(0, 1, 0, 0, 0, 16'h2000, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 0, 1, 1, "R5");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, M, 0, 0, "R5");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R5");
    cyc(0, 1, 0, 0, 0, 16'h2000, 0, 0, "R5");
    cyc(0, 1, 0, 0, 0, M, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 0, 1, 1, "R5");

    // flush
    cyc(0, 1, 0, 0, 0, M, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R6");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R6");

    // back-to-back tagged entries
    cyc(0, 1, 0, 0, 0, M, 0, 0, "R11");
    cyc(0, 1, 0, 0, 0, M, 0, 0, "R11");
    cyc(0, 0, 0, 1, 0, 0, 1, 1, "R11");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R11");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R11");

    // background lock and clock select
    st_bg_active = 1;
    cmd(2'b01, 16'h0005);
    rd_ctrl("R8 R10", 8'h1D);
    cmd(2'b01, 16'h0001);
    rd_ctrl("R10", 8'h19);

    // read-only status
    st_wait = 1; st_wait_flag = 1; st_data_valid = 1;
    cmd(2'b01, 16'h0009);
    rd_ctrl("R9", 8'hF9);
    st_bg_active = 0; st_wait = 0; st_wait_flag = 0; st_data_valid = 0;
    cmd(2'b01, 16'h00F8);
    rd_ctrl("R9", 8'h08);
    cmd(2'b01, 16'h0000);
    rd_ctrl("R8", 8'h00);

    // tag while disabled is not kept
    cyc(0, 1, 0, 0, 0, M, 0, 0, "R7");
    cmd(2'b01, 16'h0001);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R7");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R11 watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule